// File: doc/BRIEF.md
# Banked Physical Address Translator

This block widens a 16-bit CPU address into a much wider physical address. The two most significant CPU address bits pick one of four bank slots. The 16-bit bank register in that slot becomes the upper part of the physical address. The remaining fourteen CPU bits pass through unchanged as the offset. When the block is built wide, a second set of four 16-bit top registers is stacked above the bank value. The top register is chosen by the same slot bits, which gives a 46-bit physical address instead of 30 bits.

The block can also be built with split mappings. In that case an instruction fetch uses its own bank and top sets, and ordinary data reads and writes use a separate set. The access-type input chooses between them. Translation is purely combinational. Software changes the mapping through a small indexed register port: a write lands on the clock edge, and any register can be read back at any time.

Top module: `bank_xlat`

## Requirements
- R1: Each bank register is 16 bits wide, and there are four of them, slots 0 to 3. Register index bits [3:2] choose the group: 0 is data bank, 1 is data top, 2 is fetch bank, 3 is fetch top. Index bits [1:0] choose the slot. All 16 bits of a bank register can be written and read back.
- R2: CPU address bits [15:14] select the slot used for the access.
- R3: Physical address bits [13:0] equal CPU address bits [13:0]. Physical address bits [29:14] equal the selected bank register.
- R4: In the wide build, physical address bits [45:30] equal the top register of the same slot.
- R5: In the split build, `is_fetch_i` = 1 translates through the fetch groups and `is_fetch_i` = 0 translates through the data groups. Without the split build, both kinds of access use the data groups.
- R6: A register write takes effect on the rising clock edge. The physical address does not change before that edge, and it reflects the new value for the first access after it.
- R7: After reset, every bank register in slot n holds n and every top register holds zero, so CPU addresses map one-to-one onto the low 64 KiB of physical space.
- R8: The read port returns the current value of the indexed register. An index that names a group not built in this configuration reads zero.
- R9: In the narrow build, the output is 30 bits wide, top registers are not built, and writes to their indexes are ignored.
- R10: The physical address appears in the same cycle the CPU address and access type are presented, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| is_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| reg_idx_i | input | 4 | Register index: group in [3:2], slot in [1:0] |
| reg_wdata_i | input | 16 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 16 | Readback of the indexed register |
| phys_addr_o | output | 46 (30 narrow) | Translated physical address |

## Verification
The write-visibility assertion only compares readback against the write data when the index is held from the write cycle into the next one. The bench keeps the index steady after every write so that this comparison is made. The hold assertion expects the address and access type to change only between clock edges. For that reason, all stimulus is driven at the falling edge and sampled a little later in the same half cycle. One wide, split instance and one narrow, unsplit instance share the same inputs. Every write therefore tests both the effect in the wide build and the ignore rule in the narrow build.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;
  localparam int unsigned GRP_W = 2;
  localparam int unsigned N_GRP = 1 << GRP_W;

  typedef enum logic [GRP_W-1:0] {
    GRP_DATA_BANK  = 2'd0,
    GRP_DATA_TOP   = 2'd1,
    GRP_FETCH_BANK = 2'd2,
    GRP_FETCH_TOP  = 2'd3
  } grp_e;

  function automatic int unsigned pa_width(int unsigned cpu_aw, int unsigned sel_w,
                                           int unsigned bank_w, bit wide);
    return (wide ? 2 * bank_w : bank_w) + cpu_aw - sel_w;
  endfunction

  function automatic bit grp_built(logic [GRP_W-1:0] g, bit wide, bit split);
    case (g)
      GRP_DATA_BANK:  return 1'b1;
      GRP_DATA_TOP:   return wide;
      GRP_FETCH_BANK: return split;
      default:        return wide && split;
    endcase
  endfunction
endpackage

// File: rtl/bank_xlat_regset.sv
module bank_xlat_regset #(
  parameter int unsigned N_SLOT    = 4,
  parameter int unsigned REG_W     = 16,
  parameter bit          IDENT_RST = 1'b1,
  parameter bit          BUILD     = 1'b1,
  localparam int unsigned SLOT_W   = $clog2(N_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  regs_o [N_SLOT]
);
  if (BUILD) begin : g_built
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      logic [REG_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= IDENT_RST ? REG_W'(s) : '0;
        else if (we_i && slot_i == SLOT_W'(s))      q <= wdata_i;
      end
      assign regs_o[s] = q;
    end
  end else begin : g_absent
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, we_i, slot_i, wdata_i};
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      assign regs_o[s] = '0;
    end
  end
endmodule

// File: rtl/bank_xlat_path.sv
module bank_xlat_path #(
  parameter int unsigned CPU_AW  = 16,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned BANK_W  = 16,
  parameter bit          WIDE_EN = 1'b1,
  localparam int unsigned N_SLOT = 1 << SEL_W,
  localparam int unsigned OFF_W  = CPU_AW - SEL_W,
  localparam int unsigned PA_W   = bank_xlat_pkg::pa_width(CPU_AW, SEL_W, BANK_W, WIDE_EN)
) (
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [BANK_W-1:0] bank_i [N_SLOT],
  input  logic [BANK_W-1:0] top_i  [N_SLOT],
  output logic [PA_W-1:0]   phys_o
);
  logic [SEL_W-1:0] sel;
  logic [OFF_W-1:0] off;
  assign sel = cpu_addr_i[CPU_AW-1 -: SEL_W];
  assign off = cpu_addr_i[OFF_W-1:0];

  if (WIDE_EN) begin : g_wide
    assign phys_o = {top_i[sel], bank_i[sel], off};
  end else begin : g_narrow
    logic [BANK_W-1:0] unused_top;
    always_comb begin
      unused_top = '0;
      for (int s = 0; s < N_SLOT; s++) unused_top = unused_top ^ top_i[s];
    end
    assign phys_o = {bank_i[sel], off};
  end
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat #(
  parameter int unsigned CPU_AW   = 16,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BANK_W   = 16,
  parameter bit          WIDE_EN  = 1'b1,
  parameter bit          SPLIT_EN = 1'b1,
  localparam int unsigned IDX_W   = bank_xlat_pkg::GRP_W + SEL_W,
  localparam int unsigned PA_W    = bank_xlat_pkg::pa_width(CPU_AW, SEL_W, BANK_W, WIDE_EN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              is_fetch_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [BANK_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [BANK_W-1:0] reg_rdata_o,
  output logic [PA_W-1:0]   phys_addr_o
);
  import bank_xlat_pkg::*;
  localparam int unsigned N_SLOT = 1 << SEL_W;

  logic [GRP_W-1:0]  grp;
  logic [SEL_W-1:0]  slot;
  logic [BANK_W-1:0] set_q [N_GRP][N_SLOT];
  logic [BANK_W-1:0] bank_sel [N_SLOT];
  logic [BANK_W-1:0] top_sel  [N_SLOT];
  logic              use_fetch;

  assign grp  = reg_idx_i[IDX_W-1 -: GRP_W];
  assign slot = reg_idx_i[SEL_W-1:0];

  for (genvar g = 0; g < N_GRP; g++) begin : g_set
    localparam bit IS_TOP = (g % 2) == 1;
    localparam bit BUILT  = grp_built(GRP_W'(g), WIDE_EN, SPLIT_EN);
    bank_xlat_regset #(
      .N_SLOT(N_SLOT), .REG_W(BANK_W), .IDENT_RST(!IS_TOP), .BUILD(BUILT)
    ) u_set (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (reg_we_i && grp == GRP_W'(g)),
      .slot_i (slot),
      .wdata_i(reg_wdata_i),
      .regs_o (set_q[g])
    );
  end

  if (SPLIT_EN) begin : g_split
    assign use_fetch = is_fetch_i;
  end else begin : g_shared
    logic unused_fetch;
    assign unused_fetch = is_fetch_i;
    assign use_fetch    = 1'b0;
  end

  always_comb begin
    for (int s = 0; s < N_SLOT; s++) begin
      bank_sel[s] = use_fetch ? set_q[GRP_FETCH_BANK][s] : set_q[GRP_DATA_BANK][s];
      top_sel[s]  = use_fetch ? set_q[GRP_FETCH_TOP][s]  : set_q[GRP_DATA_TOP][s];
    end
  end

  bank_xlat_path #(
    .CPU_AW(CPU_AW), .SEL_W(SEL_W), .BANK_W(BANK_W), .WIDE_EN(WIDE_EN)
  ) u_path (
    .cpu_addr_i(cpu_addr_i),
    .bank_i    (bank_sel),
    .top_i     (top_sel),
    .phys_o    (phys_addr_o)
  );

  assign reg_rdata_o = set_q[grp][slot];
endmodule

// File: rtl/bank_xlat_chk.sv
module bank_xlat_chk #(
  parameter int unsigned CPU_AW   = 16,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BANK_W   = 16,
  parameter bit          WIDE_EN  = 1'b1,
  parameter bit          SPLIT_EN = 1'b1,
  localparam int unsigned IDX_W   = bank_xlat_pkg::GRP_W + SEL_W,
  localparam int unsigned OFF_W   = CPU_AW - SEL_W,
  localparam int unsigned PA_W    = bank_xlat_pkg::pa_width(CPU_AW, SEL_W, BANK_W, WIDE_EN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CPU_AW-1:0] cpu_addr_i,
  input logic              is_fetch_i,
  input logic [IDX_W-1:0]  reg_idx_i,
  input logic [BANK_W-1:0] reg_wdata_i,
  input logic              reg_we_i,
  input logic [BANK_W-1:0] reg_rdata_o,
  input logic [PA_W-1:0]   phys_addr_o
);
  logic impl;
  assign impl = bank_xlat_pkg::grp_built(reg_idx_i[IDX_W-1 -: bank_xlat_pkg::GRP_W],
                                         WIDE_EN, SPLIT_EN);

  AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[OFF_W-1:0] == cpu_addr_i[OFF_W-1:0]); // R3

  AST_WRITE_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && impl |=> (reg_idx_i != $past(reg_idx_i)) || (reg_rdata_o == $past(reg_wdata_i))); // R6

  AST_UNIMP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !impl |-> reg_rdata_o == '0); // R8

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_we_i) && $stable(cpu_addr_i) && $stable(is_fetch_i) |-> $stable(phys_addr_o)); // R10
endmodule

bind bank_xlat bank_xlat_chk #(
  .CPU_AW(CPU_AW), .SEL_W(SEL_W), .BANK_W(BANK_W), .WIDE_EN(WIDE_EN), .SPLIT_EN(SPLIT_EN)
) u_chk (.*);

// File: tb/bank_xlat_bench.sv
`timescale 1ns/1ps
module bank_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        is_fetch = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] rdata_w, rdata_n;
  logic [45:0] phys_w;
  logic [29:0] phys_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] mdl [4][4];

  always #2.5 clk = ~clk;

  bank_xlat u_bank_xlat (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .is_fetch_i(is_fetch),
    .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we),
    .reg_rdata_o(rdata_w), .phys_addr_o(phys_w));

  bank_xlat #(.WIDE_EN(1'b0), .SPLIT_EN(1'b0)) u_bank_xlat_narrow (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .is_fetch_i(is_fetch),
    .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata), .reg_we_i(reg_we),
    .reg_rdata_o(rdata_n), .phys_addr_o(phys_n));

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [45:0] exp_wide(logic [15:0] a, logic f);
    return {mdl[f ? 3 : 1][a[15:14]], mdl[f ? 2 : 0][a[15:14]], a[13:0]};
  endfunction

  function automatic logic [29:0] exp_narrow(logic [15:0] a);
    return {mdl[0][a[15:14]], a[13:0]};
  endfunction

  task automatic wr(logic [3:0] idx, logic [15:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    mdl[idx[3:2]][idx[1:0]] = d;
  endtask

  task automatic xl(string tag, logic [15:0] a, logic f);
    @(negedge clk);
    cpu_addr = a; is_fetch = f;
    #1;
    cmp({tag, " wide"}, 64'(phys_w), 64'(exp_wide(a, f)));
    cmp({tag, " narrow"}, 64'(phys_n), 64'(exp_narrow(a)));
  endtask

  task automatic rd(string tag, logic [3:0] idx);
    @(negedge clk);
    reg_idx = idx;
    #1;
    cmp({tag, " rd wide"}, 64'(rdata_w), 64'(mdl[idx[3:2]][idx[1:0]]));
    cmp({tag, " rd narrow"}, 64'(rdata_n), 64'(idx[3:2] == 2'd0 ? mdl[0][idx[1:0]] : 16'h0));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) rd("R7 R8 reset", 4'(i));
    for (int s = 0; s < 4; s++) begin
      xl("R7 identity data", {2'(s), 14'h0123}, 1'b0);
      xl("R7 identity fetch", {2'(s), 14'h3ffe}, 1'b1);
    end
  endtask

  task automatic t_bank_rw;
    wr(4'h0, 16'hffff); wr(4'h1, 16'h8001); wr(4'h2, 16'h5a5a); wr(4'h3, 16'h0000);
    for (int s = 0; s < 4; s++) rd("R1 bank", 4'(s));
  endtask

  task automatic t_data_map;
    xl("R2 R3 slot0", 16'h0000, 1'b0);
    xl("R2 R3 slot0 top", 16'h3fff, 1'b0);
    xl("R2 R3 slot1", 16'h4abc, 1'b0);
    xl("R2 R3 slot2", 16'h8001, 1'b0);
    xl("R2 R3 slot3", 16'hffff, 1'b0);
  endtask

  task automatic t_top;
    wr(4'h4, 16'hdead); wr(4'h5, 16'h0001); wr(4'h6, 16'h8000); wr(4'h7, 16'hffff);
    for (int s = 4; s < 8; s++) rd("R4 R9 top", 4'(s));
    for (int s = 0; s < 4; s++) xl("R4 top map", {2'(s), 14'h1555}, 1'b0);
  endtask

  task automatic t_split;
    wr(4'h8, 16'h1111); wr(4'h9, 16'h2222); wr(4'ha, 16'h3333); wr(4'hb, 16'h4444);
    wr(4'hd, 16'hbeef);
    for (int s = 8; s < 16; s++) rd("R5 R8 fetch set", 4'(s));
    for (int s = 0; s < 4; s++) begin
      xl("R5 fetch", {2'(s), 14'h2aaa}, 1'b1);
      xl("R5 data", {2'(s), 14'h2aaa}, 1'b0);
    end
  endtask

  task automatic t_edge;
    @(negedge clk);
    cpu_addr = 16'h4321; is_fetch = 1'b0;
    reg_idx = 4'h1; reg_wdata = 16'hc0de; reg_we = 1'b1;
    #1;
    cmp("R6 before edge", 64'(phys_w), 64'(exp_wide(16'h4321, 1'b0)));
    @(posedge clk);
    #1;
    mdl[0][1] = 16'hc0de;
    cmp("R6 R10 after edge wide", 64'(phys_w), 64'(exp_wide(16'h4321, 1'b0)));
    cmp("R6 R10 after edge narrow", 64'(phys_n), 64'(exp_narrow(16'h4321)));
    @(negedge clk);
    reg_we = 1'b0;
    rd("R6 readback", 4'h1);
    xl("R10 same cycle", 16'h7fff, 1'b1);
    xl("R10 same cycle back", 16'h0001, 1'b0);
  endtask

  task automatic t_narrow_ignore;
    // narrow build: writes to top groups are ignored, output stays 30 bits
    wr(4'h6, 16'h7777);
    rd("R9 narrow top ignored", 4'h6);
    xl("R9 narrow map", 16'h8123, 1'b0);
    xl("R9 narrow fetch shares data", 16'h8123, 1'b1);
  endtask

  initial begin
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 4; s++) mdl[g][s] = (g % 2 == 0) ? 16'(s) : 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bank_rw();
    t_data_map();
    t_top();
    t_split();
    t_edge();
    t_narrow_ignore();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule